// File: doc/BRIEF.md
# Serial-Bus Node State and Split-Timeout Register Block

This block holds the control and status registers that a serial-bus node exposes to its peers. It provides a node state word with bit-set and bit-clear commands, a pair of split-timeout registers, and a fixed capabilities word. From the two timeout registers it keeps a single split-timeout count in bus cycles, and internal transaction timers use this count directly.

The block also does the state bookkeeping that every bus reset requires. A single-cycle bus-reset pulse, together with the node's current root status and its cycle-master capability, decides whether the cycle-master bit is kept, raised or dropped. The block drives a cycle-start enable to the cycle timer. A private flag records whether the node was already root at the previous bus reset.

Access goes through a plain register port. A 2-bit address selects the word. A read strobe returns data combinationally in the same cycle. A write strobe stores write data at the next clock edge. The set and clear strobes use the write data as a bit mask for the state word.

Top module: `sbus_csr_regs`

## Requirements
- R1: A write to the timeout-high word (address 1) keeps only write-data bits 2:0. A read returns that value in bits 2:0, with all upper bits zero.
- R2: A write to the timeout-low word (address 2) takes its field from write-data bits 31:19. A field below 800 is stored as 800, and a field above 7999 is stored as 7999.
- R3: A read of the timeout-low word returns the stored 13-bit field in bits 31:19 and zero in bits 18:0.
- R4: The split-timeout output equals high*8000 + low. It changes only on the clock edge that stores a timeout write, and is valid from the next cycle on.
- R5: Set and clear strobes act on the state word (address 0) only, and only on bit 8 (cycle master), bit 9 (dreq) and bit 10 (abdicate). All other bits read zero. When a set and a clear of the same bit arrive in the same cycle, the clear wins. A plain write strobe to the state word has no effect.
- R6: While the root input is high, a set command that includes bit 8 raises the cycle-start enable and a clear command that includes bit 8 lowers it, with the clear winning if both arrive together. While the root input is low, commands leave the enable unchanged.
- R7: Every bus-reset pulse clears the abdicate bit. If the node is not root, the pulse also clears the cycle-master bit and the was-root flag and leaves the cycle-start enable unchanged. Set and clear commands in the same cycle as a bus-reset pulse are dropped.
- R8: On a bus-reset pulse while root and not previously root, the was-root flag is set, and both the cycle-master bit and the cycle-start enable take the value of the cycle-master-capable input.
- R9: On a bus-reset pulse while root and already root, the cycle-master bit and the cycle-start enable keep their values.
- R10: Synchronous reset sets the state word to 0, the cycle-start enable to 0, the was-root flag to false, high to 0 and low to the LO_DEFAULT parameter (800). The capabilities word (address 3) always reads 0x000083C0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 state, 1 timeout high, 2 timeout low, 3 capabilities |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| wr_en | input | 1 | Write strobe |
| set_en | input | 1 | Bit-set command on the state word, mask in wdata |
| clr_en | input | 1 | Bit-clear command on the state word, mask in wdata |
| wdata | input | 32 | Write data or command mask |
| rdata | output | 32 | Read data, zero when rd_en is low |
| bus_reset | input | 1 | One-cycle bus-reset pulse |
| is_root | input | 1 | The node is currently root |
| cm_capable | input | 1 | The node is able to act as cycle master |
| cyc_start_en | output | 1 | Enable for cycle-start generation |
| split_timeout | output | 16 | Combined split timeout in bus cycles |

## Verification
The hardest case to reach is the bus-reset step that depends on the was-root flag. The flag cannot be read at any port, so its value can only be inferred from how a later bus reset treats the cycle-master bit. The stimulus drives the cycle-start enable high through commands while root, then sends bus resets with the root input low, then high with capability absent, then high again, and finally low followed by high with capability present. Each case is checked through the state word and the enable. The clamp edges and the same-cycle set/clear conflict are driven with dedicated single-cycle commands.

// File: rtl/sbus_csr_pkg.sv
package sbus_csr_pkg;

    localparam int DATA_W     = 32;
    localparam int SEL_W      = 2;
    localparam int BIT_CMSTR  = 8;
    localparam int BIT_DREQ   = 9;
    localparam int BIT_ABDIC  = 10;
    localparam logic [DATA_W-1:0] NODE_CAP_WORD = 32'h0000_83C0;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATE = 2'd0,
        SEL_TO_HI = 2'd1,
        SEL_TO_LO = 2'd2,
        SEL_CAP   = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic abdicate;
        logic dreq;
        logic cmstr;
    } state_bits_t;

    function automatic state_bits_t mask_to_bits(input logic [DATA_W-1:0] m);
        state_bits_t b;
        b.abdicate = m[BIT_ABDIC];
        b.dreq     = m[BIT_DREQ];
        b.cmstr    = m[BIT_CMSTR];
        return b;
    endfunction

    function automatic logic [DATA_W-1:0] bits_to_word(input state_bits_t b);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[BIT_ABDIC] = b.abdicate;
        w[BIT_DREQ]  = b.dreq;
        w[BIT_CMSTR] = b.cmstr;
        return w;
    endfunction

endpackage

// File: rtl/sbus_csr_state.sv
module sbus_csr_state
    import sbus_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  state_bits_t set_m,
    input  state_bits_t clr_m,
    input  logic        bus_reset,
    input  logic        is_root,
    input  logic        cm_capable,
    output state_bits_t st,
    output logic        cyc_start_en
);

    state_bits_t st_q;
    logic        was_root_q;
    logic        cs_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            was_root_q <= 1'b0;
            cs_en_q    <= 1'b0;
        end else if (bus_reset) begin
            st_q.abdicate <= 1'b0;
            if (!is_root) begin
                was_root_q <= 1'b0;
                st_q.cmstr <= 1'b0;
            end else if (!was_root_q) begin
                was_root_q <= 1'b1;
                st_q.cmstr <= cm_capable;
                cs_en_q    <= cm_capable;
            end
        end else begin
            st_q <= (st_q | set_m) & ~clr_m;
            if (is_root && clr_m.cmstr)
                cs_en_q <= 1'b0;
            else if (is_root && set_m.cmstr)
                cs_en_q <= 1'b1;
        end
    end

    assign st           = st_q;
    assign cyc_start_en = cs_en_q;

    // R5: clear takes priority over set for the same bit
    p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (!bus_reset && set_m.dreq && clr_m.dreq) |=> !st_q.dreq);

    // R6: with the node not root, commands never move the enable
    p_cs_nonroot_r6: assert property (@(posedge clk) disable iff (rst)
        (!bus_reset && !is_root) |=> $stable(cs_en_q));

    // R7: bus reset always drops abdicate
    p_abdic_r7: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !st_q.abdicate);

    // R7: non-root bus reset clears cmstr and was_root, keeps the enable
    p_nonroot_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_reset && !is_root) |=> (!st_q.cmstr && !was_root_q && $stable(cs_en_q)));

    // R8: new root follows capability
    p_newroot_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_reset && is_root && !was_root_q) |=>
        (was_root_q && st_q.cmstr == $past(cm_capable) && cs_en_q == $past(cm_capable)));

    // R9: continuing root keeps cmstr and the enable
    p_keeproot_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_reset && is_root && was_root_q) |=> ($stable(st_q.cmstr) && $stable(cs_en_q)));

endmodule

// File: rtl/sbus_csr_timeout.sv
module sbus_csr_timeout #(
    parameter int HI_W        = 3,
    parameter int LO_W        = 13,
    parameter int CYC_PER_SEC = 8000,
    parameter int LO_MIN      = 800,
    parameter int LO_MAX      = 7999,
    parameter int LO_DEFAULT  = 800,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_wr,
    input  logic              lo_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [HI_W-1:0]   hi_val,
    output logic [LO_W-1:0]   lo_val,
    output logic [CNT_W-1:0]  count
);

    localparam int LO_SHIFT = DATA_W - LO_W;
    localparam logic [LO_W-1:0]  LO_MIN_V = LO_W'(LO_MIN);
    localparam logic [LO_W-1:0]  LO_MAX_V = LO_W'(LO_MAX);
    localparam logic [LO_W-1:0]  LO_DEF_V = LO_W'(LO_DEFAULT);
    localparam logic [CNT_W-1:0] CYC_V    = CNT_W'(CYC_PER_SEC);

    logic [HI_W-1:0]  hi_q, hi_d;
    logic [LO_W-1:0]  lo_q, lo_d, lo_field, lo_clamped;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        lo_field = wdata[DATA_W-1:LO_SHIFT];
        if (lo_field < LO_MIN_V)
            lo_clamped = LO_MIN_V;
        else if (lo_field > LO_MAX_V)
            lo_clamped = LO_MAX_V;
        else
            lo_clamped = lo_field;
        hi_d  = hi_wr ? wdata[HI_W-1:0] : hi_q;
        lo_d  = lo_wr ? lo_clamped : lo_q;
        cnt_d = CNT_W'(hi_d) * CYC_V + CNT_W'(lo_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            lo_q  <= LO_DEF_V;
            cnt_q <= CNT_W'(LO_DEFAULT);
        end else if (hi_wr || lo_wr) begin
            hi_q  <= hi_d;
            lo_q  <= lo_d;
            cnt_q <= cnt_d;
        end
    end

    assign hi_val = hi_q;
    assign lo_val = lo_q;
    assign count  = cnt_q;

    // R1: high register takes the low bits of the write
    p_hi_wr_r1: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> (hi_q == $past(wdata[HI_W-1:0])));

    // R2: stored low field always inside the clamp window
    p_lo_range_r2: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> (lo_q >= LO_MIN_V && lo_q <= LO_MAX_V));

    // R4: count only moves on a timeout write
    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!hi_wr && !lo_wr) |=> $stable(count));

endmodule

// File: rtl/sbus_csr_rdmux.sv
module sbus_csr_rdmux
    import sbus_csr_pkg::*;
#(
    parameter int HI_W = 3,
    parameter int LO_W = 13
) (
    input  logic              rd_en,
    input  csr_sel_e          sel,
    input  state_bits_t       st,
    input  logic [HI_W-1:0]   hi_val,
    input  logic [LO_W-1:0]   lo_val,
    output logic [DATA_W-1:0] rdata
);

    localparam int LO_SHIFT = DATA_W - LO_W;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_STATE: rdata = bits_to_word(st);
                SEL_TO_HI: rdata = DATA_W'(hi_val);
                SEL_TO_LO: rdata = {lo_val, {LO_SHIFT{1'b0}}};
                SEL_CAP:   rdata = NODE_CAP_WORD;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sbus_csr_regs.sv
module sbus_csr_regs
    import sbus_csr_pkg::*;
#(
    parameter int HI_W        = 3,
    parameter int LO_W        = 13,
    parameter int CYC_PER_SEC = 8000,
    parameter int LO_MIN      = 800,
    parameter int LO_MAX      = 7999,
    parameter int LO_DEFAULT  = 800,
    parameter int CNT_W       = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  addr,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic        set_en,
    input  logic        clr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        bus_reset,
    input  logic        is_root,
    input  logic        cm_capable,
    output logic        cyc_start_en,
    output logic [15:0] split_timeout
);

    localparam int LO_SHIFT = DATA_W - LO_W;

    csr_sel_e        sel;
    state_bits_t     set_m, clr_m, st;
    logic            hi_wr, lo_wr;
    logic [HI_W-1:0] hi_val;
    logic [LO_W-1:0] lo_val;

    always_comb begin
        sel   = csr_sel_e'(addr);
        set_m = (set_en && sel == SEL_STATE) ? mask_to_bits(wdata) : '0;
        clr_m = (clr_en && sel == SEL_STATE) ? mask_to_bits(wdata) : '0;
        hi_wr = wr_en && (sel == SEL_TO_HI);
        lo_wr = wr_en && (sel == SEL_TO_LO);
    end

    sbus_csr_state u_state (
        .clk          (clk),
        .rst          (rst),
        .set_m        (set_m),
        .clr_m        (clr_m),
        .bus_reset    (bus_reset),
        .is_root      (is_root),
        .cm_capable   (cm_capable),
        .st           (st),
        .cyc_start_en (cyc_start_en)
    );

    sbus_csr_timeout #(
        .HI_W        (HI_W),
        .LO_W        (LO_W),
        .CYC_PER_SEC (CYC_PER_SEC),
        .LO_MIN      (LO_MIN),
        .LO_MAX      (LO_MAX),
        .LO_DEFAULT  (LO_DEFAULT),
        .CNT_W       (CNT_W),
        .DATA_W      (DATA_W)
    ) u_timeout (
        .clk    (clk),
        .rst    (rst),
        .hi_wr  (hi_wr),
        .lo_wr  (lo_wr),
        .wdata  (wdata),
        .hi_val (hi_val),
        .lo_val (lo_val),
        .count  (split_timeout)
    );

    sbus_csr_rdmux #(
        .HI_W (HI_W),
        .LO_W (LO_W)
    ) u_rdmux (
        .rd_en  (rd_en),
        .sel    (sel),
        .st     (st),
        .hi_val (hi_val),
        .lo_val (lo_val),
        .rdata  (rdata)
    );

    // R3: low-word reads never carry data below the field
    p_lo_read_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_TO_LO) |-> (rdata[LO_SHIFT-1:0] == '0));

    // R5: state reads expose only the three supported bits
    p_state_bits_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_STATE) |-> ((rdata & ~32'h0000_0700) == '0));

    // R10: capabilities word is constant
    p_cap_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_CAP) |-> (rdata == 32'h0000_83C0));

endmodule

// File: tb/sim_sbus_csr_regs.sv
`timescale 1ns/1ps
module sim_sbus_csr_regs;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0, set_en = 1'b0, clr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        bus_reset = 1'b0, is_root = 1'b0, cm_capable = 1'b0;
    logic        cyc_start_en;
    logic [15:0] split_timeout;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    sbus_csr_regs u0 (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .set_en(set_en), .clr_en(clr_en), .wdata(wdata), .rdata(rdata),
        .bus_reset(bus_reset), .is_root(is_root), .cm_capable(cm_capable),
        .cyc_start_en(cyc_start_en), .split_timeout(split_timeout)
    );

    // monitor: pops expected read data mid-cycle
    always @(negedge clk) begin
        if (!rst && rd_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard empty: actual %h expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    fails++;
                    $display("FAIL %s read addr %0d: actual %h expected %h", t, addr, rdata, e);
                end
            end
        end
    end

    function automatic int clamp_lo(input int f);
        if (f < 800) return 800;
        if (f > 7999) return 7999;
        return f;
    endfunction

    task automatic pulse(input logic [1:0] a, input logic w, input logic s,
                         input logic c, input logic br, input logic [31:0] d);
        @(posedge clk); #1;
        addr = a; wr_en = w; set_en = s; clr_en = c; bus_reset = br; wdata = d;
        @(posedge clk); #1;
        wr_en = 0; set_en = 0; clr_en = 0; bus_reset = 0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        addr = a; rd_en = 1;
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic chk_out(input logic cs, input int cnt, input string t);
        @(negedge clk);
        checks++;
        if (cyc_start_en !== cs) begin
            fails++;
            $display("FAIL %s cyc_start_en: actual %0b expected %0b", t, cyc_start_en, cs);
        end
        checks++;
        if (split_timeout !== 16'(cnt)) begin
            fails++;
            $display("FAIL %s split_timeout: actual %0d expected %0d", t, split_timeout, cnt);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int hi, lo;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R10 reset state
        rd(0, 32'h0, "R10");
        rd(1, 32'h0, "R10");
        rd(2, 32'(800) << 19, "R10");
        rd(3, 32'h0000_83C0, "R10");
        chk_out(0, 800, "R10");
        pulse(3, 1, 0, 0, 0, 32'hFFFF_FFFF);
        rd(3, 32'h0000_83C0, "R10");

        // R1 / R4 high word
        hi = 32'hFFFF_FFFD & 7; lo = 800;
        pulse(1, 1, 0, 0, 0, 32'hFFFF_FFFD);
        rd(1, 32'(hi), "R1");
        chk_out(0, hi * 8000 + lo, "R4");

        // R2 / R3 clamps and field
        pulse(2, 1, 0, 0, 0, 32'(100) << 19);
        lo = clamp_lo(100);
        rd(2, 32'(lo) << 19, "R2");
        pulse(2, 1, 0, 0, 0, 32'(8100) << 19);
        lo = clamp_lo(8100);
        rd(2, 32'(lo) << 19, "R2");
        chk_out(0, hi * 8000 + lo, "R4");
        pulse(2, 1, 0, 0, 0, (32'(1234) << 19) | 32'h7FFFF);
        lo = clamp_lo(1234);
        rd(2, 32'(lo) << 19, "R3");
        pulse(1, 1, 0, 0, 0, 32'h7);
        hi = 7;
        chk_out(0, hi * 8000 + lo, "R4");

        // R5 state commands, not root
        is_root = 0;
        pulse(0, 0, 1, 0, 0, 32'hFFFF_FFFF);
        rd(0, 32'h700, "R5");
        chk_out(0, hi * 8000 + lo, "R6");
        pulse(0, 1, 0, 0, 0, 32'h0);
        rd(0, 32'h700, "R5");
        pulse(0, 0, 0, 1, 0, 32'h100);
        rd(0, 32'h600, "R5");
        pulse(0, 0, 1, 1, 0, 32'h200);
        rd(0, 32'h400, "R5");
        pulse(1, 0, 1, 0, 0, 32'h300);
        rd(0, 32'h400, "R5");

        // R6 enable via commands while root
        is_root = 1;
        pulse(0, 0, 1, 0, 0, 32'h100);
        rd(0, 32'h500, "R6");
        chk_out(1, hi * 8000 + lo, "R6");
        pulse(0, 0, 0, 1, 0, 32'h100);
        chk_out(0, hi * 8000 + lo, "R6");
        pulse(0, 0, 1, 1, 0, 32'h100);
        chk_out(0, hi * 8000 + lo, "R6");
        pulse(0, 0, 1, 0, 0, 32'h300);
        rd(0, 32'h700, "R6");
        chk_out(1, hi * 8000 + lo, "R6");

        // R7 non-root bus reset
        is_root = 0;
        pulse(0, 0, 0, 0, 1, 32'h0);
        rd(0, 32'h200, "R7");
        chk_out(1, hi * 8000 + lo, "R7");

        // R8 new root, not capable
        is_root = 1; cm_capable = 0;
        pulse(0, 0, 0, 0, 1, 32'h0);
        rd(0, 32'h200, "R8");
        chk_out(0, hi * 8000 + lo, "R8");

        // R9 continuing root keeps cmstr/enable
        pulse(0, 0, 1, 0, 0, 32'h100);
        chk_out(1, hi * 8000 + lo, "R6");
        pulse(0, 0, 0, 0, 1, 32'h0);
        rd(0, 32'h300, "R9");
        chk_out(1, hi * 8000 + lo, "R9");
        pulse(0, 0, 1, 0, 0, 32'h400);
        rd(0, 32'h700, "R5");
        pulse(0, 0, 0, 0, 1, 32'h0);
        rd(0, 32'h300, "R7");

        // R8 new root, capable
        is_root = 0;
        pulse(0, 0, 0, 0, 1, 32'h0);
        rd(0, 32'h200, "R7");
        is_root = 1; cm_capable = 1;
        pulse(0, 0, 0, 1, 0, 32'h0);
        pulse(0, 0, 0, 0, 1, 32'h0);
        rd(0, 32'h300, "R8");
        chk_out(1, hi * 8000 + lo, "R8");
        pulse(0, 0, 0, 1, 0, 32'h100);
        chk_out(0, hi * 8000 + lo, "R6");
        pulse(0, 0, 0, 0, 1, 32'h0);
        rd(0, 32'h200, "R9");
        chk_out(0, hi * 8000 + lo, "R9");

        // R7 command dropped during bus reset
        pulse(0, 0, 1, 0, 1, 32'h500);
        rd(0, 32'h200, "R7");
        chk_out(0, hi * 8000 + lo, "R7");

        // R10 reset again
        @(posedge clk); #1 rst = 1;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        rd(0, 32'h0, "R10");
        rd(1, 32'h0, "R10");
        chk_out(0, 800, "R10");

        repeat (3) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard left: actual %0d expected 0", exp_q.size());
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule